// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block turns slot-level hot-plug commands into single-register accesses. It passes those accesses to a transaction sequencer beneath it. A command is a code with a read/write flag, a slot number and a bus number. The engine maps the command to a register index. It makes sure the controller is idle before it touches that register. It returns the resulting bytes together with an error code.

Every access is guarded. First the engine reads the controller status register at index 0x0F until the busy flag clears. Between two reads it waits for a retry strobe from outside, so the spacing between retries comes from the system. It does not use an internal timer. After a write, some commands also wait for the controller to report that it has finished. A combined-status read fetches the slot status, waits for the controller to go idle again, and then fetches the extended status.

Top module: `hp_slot_cmd_engine`

## Requirements
- R1: A write command with a controller-wide code targets index 0x0F, and the command code is the write data. The controller-wide codes are 0x00, 0x01, 0x06, 0x07, 0x08, 0x11 and 0x12.
- R2: The slot write codes 0x02, 0x03, 0x04, 0x05 and 0x13 target the slot index. The bus write codes 0x20 to 0x24 target bus index + 0x1E, modulo 256.
- R3: These read codes (cmd_write=0) each produce one read:
  - 1 reads the slot index.
  - 2 reads slot + 0x10.
  - 3 reads bus + 0x1E.
  - 4 reads 0x28.
  - 5 reads 0x25.
  - 6 reads 0x27.
  - The value read is returned in rsp_status.
- R4: Any other code gives rsp_err=1. The engine makes no access, and rsp_status, rsp_ext and rsp_ctlr are zero.
- R5: Every access is preceded by reads of index 0x0F. When the busy flag is set (status bit BUSY_BIT, default 0), the engine waits for a tick pulse and reads again.
- R6: If MAX_TRIES consecutive status reads all show busy, the command ends with rsp_err=2, and the guarded access is not made. A run of MAX_TRIES-1 busy reads followed by an idle read still proceeds.
- R7: Read code 7 (combined status) works in three steps. It reads the slot index, waits for idle again, and then reads slot + 0x10. The slot byte goes to rsp_status and the extended byte goes to rsp_ext. If the second wait times out, the extended read is skipped and rsp_err=2.
- R8: Some write codes need a completion check; these are set by CHK_MASK, and by default they are 0x02 and 0x03. After such a write, the engine repeats the guarded status read on each tick until the finished flag is set (bit DONE_BIT, default 1). After MAX_TRIES unfinished idle reads it ends with rsp_err=3.
- R9: A write code without the completion check ends after the first idle status read that follows the write, with rsp_err=0.
- R10: rsp_ctlr holds the last controller status that was read. Read code 0 returns that status in rsp_status and makes no further access.
- R11: Each accepted command produces exactly one single-cycle rsp_valid pulse. cmd_ready is high only when the engine is idle.
- R12: Once acc_req rises, it stays high with acc_index and acc_write unchanged until acc_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Retry strobe, one pulse per retry interval |
| cmd_valid | input | 1 | Command present; taken when cmd_ready is high |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_code | input | 8 | Command code |
| slot_idx | input | 8 | Slot number within the controller |
| bus_idx | input | 8 | Bus number |
| acc_req | output | 1 | Access request to the sequencer, held until acc_done |
| acc_write | output | 1 | Access is a write |
| acc_index | output | 8 | Controller register index |
| acc_wdata | output | 8 | Write data |
| acc_done | input | 1 | Access complete, one-cycle pulse |
| acc_rdata | input | 8 | Read data, valid with acc_done |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 2 | 0 ok, 1 bad command, 2 busy timeout, 3 completion timeout |
| rsp_status | output | 8 | Slot, register or controller status byte |
| rsp_ext | output | 8 | Extended slot status (combined read) |
| rsp_ctlr | output | 8 | Last controller status read |

## Verification
The hardest situation to reach is an idle wait that fails in the middle of a combined-status read. In that case the slot byte has already been fetched, the extended byte must never be fetched, and the busy count must restart after the first idle reading. The bench model queues controller status values in advance. It can therefore give one idle reading and then exactly MAX_TRIES busy readings. The same queue produces the boundary cases of MAX_TRIES-1 busy readings and MAX_TRIES unfinished readings after a write.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

    localparam int unsigned BYTE_W = 8;

    // register indices
    localparam logic [7:0] CTLR_IDX  = 8'h0F;
    localparam logic [7:0] EXT_OFS   = 8'h10;
    localparam logic [7:0] BUS_OFS   = 8'h1E;
    localparam logic [7:0] LATCH_IDX = 8'h28;
    localparam logic [7:0] REV_IDX   = 8'h25;
    localparam logic [7:0] OPT_IDX   = 8'h27;

    // read codes
    localparam logic [7:0] RD_CTLR  = 8'h00;
    localparam logic [7:0] RD_SLOT  = 8'h01;
    localparam logic [7:0] RD_EXT   = 8'h02;
    localparam logic [7:0] RD_BUS   = 8'h03;
    localparam logic [7:0] RD_LATCH = 8'h04;
    localparam logic [7:0] RD_REV   = 8'h05;
    localparam logic [7:0] RD_OPT   = 8'h06;
    localparam logic [7:0] RD_COMBO = 8'h07;

    // write codes: controller-wide
    localparam logic [7:0] WR_IRQ_EN    = 8'h00;
    localparam logic [7:0] WR_IRQ_DIS   = 8'h01;
    localparam logic [7:0] WR_IRQ_CLR   = 8'h06;
    localparam logic [7:0] WR_CTL_RESET = 8'h07;
    localparam logic [7:0] WR_IRQ_ROUTE = 8'h08;
    localparam logic [7:0] WR_ALL_ON    = 8'h11;
    localparam logic [7:0] WR_ALL_OFF   = 8'h12;
    // write codes: per slot
    localparam logic [7:0] WR_PWR_OFF   = 8'h02;
    localparam logic [7:0] WR_PWR_ON    = 8'h03;
    localparam logic [7:0] WR_IND_OFF   = 8'h04;
    localparam logic [7:0] WR_IND_ON    = 8'h05;
    localparam logic [7:0] WR_IND_BLINK = 8'h13;
    // write codes: per bus speed mode
    localparam logic [7:0] WR_BUS_M0    = 8'h20;
    localparam logic [7:0] WR_BUS_M4    = 8'h24;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_BADCMD  = 2'd1,
        ERR_BUSY_TO = 2'd2,
        ERR_DONE_TO = 2'd3
    } hpe_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_WAIT,
        ST_ACC,
        ST_EXT,
        ST_RESP
    } hpe_state_e;

    typedef enum logic [1:0] {
        PH_PRE,
        PH_MID,
        PH_POST
    } hpe_phase_e;

    typedef struct packed {
        logic       ok;
        logic [7:0] idx;
        logic       ctlr_rd;
        logic       combo;
        logic       chk;
    } hpe_map_t;

    function automatic logic is_ctlr_wr(input logic [7:0] c);
        return (c == WR_IRQ_EN) || (c == WR_IRQ_DIS) || (c == WR_IRQ_CLR) ||
               (c == WR_CTL_RESET) || (c == WR_IRQ_ROUTE) ||
               (c == WR_ALL_ON) || (c == WR_ALL_OFF);
    endfunction

    function automatic logic is_slot_wr(input logic [7:0] c);
        return (c == WR_PWR_OFF) || (c == WR_PWR_ON) || (c == WR_IND_OFF) ||
               (c == WR_IND_ON) || (c == WR_IND_BLINK);
    endfunction

    function automatic logic is_bus_wr(input logic [7:0] c);
        return (c >= WR_BUS_M0) && (c <= WR_BUS_M4);
    endfunction

endpackage

// File: rtl/hpe_index_map.sv
module hpe_index_map
    import hpe_pkg::*;
#(
    parameter logic [63:0] CHK_MASK = 64'h0000_0000_0000_000C
) (
    input  logic       is_wr,
    input  logic [7:0] code,
    input  logic [7:0] slot,
    input  logic [7:0] bus,
    output hpe_map_t   map
);

    always_comb begin
        map = '0;
        if (is_wr) begin
            if (is_ctlr_wr(code)) begin
                map.ok  = 1'b1;
                map.idx = CTLR_IDX;
            end else if (is_slot_wr(code)) begin
                map.ok  = 1'b1;
                map.idx = slot;
            end else if (is_bus_wr(code)) begin
                map.ok  = 1'b1;
                map.idx = bus + BUS_OFS;
            end
            map.chk = map.ok && (code[7:6] == 2'b00) && CHK_MASK[code[5:0]];
        end else begin
            case (code)
                RD_CTLR:  begin map.ok = 1'b1; map.idx = CTLR_IDX; map.ctlr_rd = 1'b1; end
                RD_SLOT:  begin map.ok = 1'b1; map.idx = slot; end
                RD_EXT:   begin map.ok = 1'b1; map.idx = slot + EXT_OFS; end
                RD_BUS:   begin map.ok = 1'b1; map.idx = bus + BUS_OFS; end
                RD_LATCH: begin map.ok = 1'b1; map.idx = LATCH_IDX; end
                RD_REV:   begin map.ok = 1'b1; map.idx = REV_IDX; end
                RD_OPT:   begin map.ok = 1'b1; map.idx = OPT_IDX; end
                RD_COMBO: begin map.ok = 1'b1; map.idx = slot; map.combo = 1'b1; end
                default:  map = '0;
            endcase
        end
    end

endmodule

// File: rtl/hpe_try_ctr.sv
module hpe_try_ctr #(
    parameter int unsigned MAX_TRIES = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int unsigned CW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(MAX_TRIES - 1));

    // the sequencer must give up instead of counting past the limit
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        inc |-> !last)
        else $error("retry counter advanced past its limit");

    assert_clr_inc_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(inc && clr))
        else $error("retry counter cleared and advanced together");

endmodule

// File: rtl/hpe_fsm.sv
module hpe_fsm
    import hpe_pkg::*;
#(
    parameter int unsigned BUSY_BIT = 0,
    parameter int unsigned DONE_BIT = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic       cmd_write,
    input  logic [7:0] cmd_code,
    input  hpe_map_t   map,
    output logic       cmd_ready,
    output logic       acc_req,
    output logic       acc_write,
    output logic [7:0] acc_index,
    output logic [7:0] acc_wdata,
    input  logic       acc_done,
    input  logic [7:0] acc_rdata,
    input  logic       busy_last,
    input  logic       done_last,
    output logic       busy_inc,
    output logic       busy_clr,
    output logic       done_inc,
    output logic       done_clr,
    output logic       rsp_valid,
    output logic [1:0] rsp_err,
    output logic [7:0] rsp_status,
    output logic [7:0] rsp_ext,
    output logic [7:0] rsp_ctlr
);

    hpe_state_e state;
    hpe_phase_e phase;
    hpe_err_e   err_q;
    logic       wr_q, combo_q, ctlrrd_q, chk_q;
    logic [7:0] code_q, idx_q, stat_q, ext_q, ctlr_q;

    logic poll_ret, rd_busy, rd_fin;
    assign poll_ret = (state == ST_POLL) && acc_done;
    assign rd_busy  = acc_rdata[BUSY_BIT];
    assign rd_fin   = acc_rdata[DONE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_PRE;
            err_q    <= ERR_NONE;
            wr_q     <= 1'b0;
            combo_q  <= 1'b0;
            ctlrrd_q <= 1'b0;
            chk_q    <= 1'b0;
            code_q   <= '0;
            idx_q    <= '0;
            stat_q   <= '0;
            ext_q    <= '0;
            ctlr_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    wr_q     <= cmd_write;
                    code_q   <= cmd_code;
                    idx_q    <= map.idx;
                    combo_q  <= map.combo;
                    ctlrrd_q <= map.ctlr_rd;
                    chk_q    <= map.chk;
                    stat_q   <= '0;
                    ext_q    <= '0;
                    ctlr_q   <= '0;
                    phase    <= PH_PRE;
                    if (map.ok) begin
                        err_q <= ERR_NONE;
                        state <= ST_POLL;
                    end else begin
                        err_q <= ERR_BADCMD;
                        state <= ST_RESP;
                    end
                end
                ST_POLL: if (acc_done) begin
                    ctlr_q <= acc_rdata;
                    if (rd_busy) begin
                        if (busy_last) begin
                            err_q <= ERR_BUSY_TO;
                            state <= ST_RESP;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end else begin
                        case (phase)
                            PH_PRE: begin
                                if (ctlrrd_q) begin
                                    stat_q <= acc_rdata;
                                    state  <= ST_RESP;
                                end else begin
                                    state  <= ST_ACC;
                                end
                            end
                            PH_MID: state <= ST_EXT;
                            default: begin
                                if (chk_q && !rd_fin) begin
                                    if (done_last) begin
                                        err_q <= ERR_DONE_TO;
                                        state <= ST_RESP;
                                    end else begin
                                        state <= ST_WAIT;
                                    end
                                end else begin
                                    state <= ST_RESP;
                                end
                            end
                        endcase
                    end
                end
                ST_WAIT: if (tick) state <= ST_POLL;
                ST_ACC: if (acc_done) begin
                    if (wr_q) begin
                        phase <= PH_POST;
                        state <= ST_POLL;
                    end else begin
                        stat_q <= acc_rdata;
                        if (combo_q) begin
                            phase <= PH_MID;
                            state <= ST_POLL;
                        end else begin
                            state <= ST_RESP;
                        end
                    end
                end
                ST_EXT: if (acc_done) begin
                    ext_q <= acc_rdata;
                    state <= ST_RESP;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // access request decode
    assign acc_req   = (state == ST_POLL) || (state == ST_ACC) || (state == ST_EXT);
    assign acc_write = (state == ST_ACC) && wr_q;
    assign acc_wdata = acc_write ? code_q : 8'h00;
    always_comb begin
        case (state)
            ST_POLL: acc_index = CTLR_IDX;
            ST_EXT:  acc_index = idx_q + EXT_OFS;
            default: acc_index = idx_q;
        endcase
    end

    // retry counter controls
    assign busy_clr = (state == ST_IDLE) || (poll_ret && !rd_busy);
    assign busy_inc = poll_ret && rd_busy && !busy_last;
    assign done_clr = (state == ST_IDLE);
    assign done_inc = poll_ret && !rd_busy && (phase == PH_POST) && chk_q &&
                      !rd_fin && !done_last;

    assign cmd_ready  = (state == ST_IDLE);
    assign rsp_valid  = (state == ST_RESP);
    assign rsp_err    = err_q;
    assign rsp_status = stat_q;
    assign rsp_ext    = ext_q;
    assign rsp_ctlr   = ctlr_q;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !acc_done) |=> (acc_req && $stable(acc_index) && $stable(acc_write)))
        else $error("access request dropped or changed before completion");

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid)
        else $error("response held longer than one cycle");

    assert_req_vs_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        acc_req |-> !rsp_valid)
        else $error("response while an access is outstanding");

    assert_finished_ok_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && err_q == ERR_NONE && wr_q && chk_q) |->
        (rsp_ctlr[DONE_BIT] && !rsp_ctlr[BUSY_BIT]))
        else $error("checked write reported success without finished status");

    assert_busy_to_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && err_q == ERR_BUSY_TO) |-> rsp_ctlr[BUSY_BIT])
        else $error("busy timeout reported with idle status");

endmodule

// File: rtl/hp_slot_cmd_engine.sv
module hp_slot_cmd_engine
    import hpe_pkg::*;
#(
    parameter int unsigned  MAX_TRIES = 60,
    parameter int unsigned  BUSY_BIT  = 0,
    parameter int unsigned  DONE_BIT  = 1,
    parameter logic [63:0]  CHK_MASK  = 64'h0000_0000_0000_000C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic       cmd_write,
    input  logic [7:0] cmd_code,
    input  logic [7:0] slot_idx,
    input  logic [7:0] bus_idx,
    output logic       acc_req,
    output logic       acc_write,
    output logic [7:0] acc_index,
    output logic [7:0] acc_wdata,
    input  logic       acc_done,
    input  logic [7:0] acc_rdata,
    output logic       rsp_valid,
    output logic [1:0] rsp_err,
    output logic [7:0] rsp_status,
    output logic [7:0] rsp_ext,
    output logic [7:0] rsp_ctlr
);

    hpe_map_t map;
    logic busy_last, done_last, busy_inc, busy_clr, done_inc, done_clr;

    hpe_index_map #(.CHK_MASK(CHK_MASK)) u_map (
        .is_wr (cmd_write),
        .code  (cmd_code),
        .slot  (slot_idx),
        .bus   (bus_idx),
        .map   (map)
    );

    hpe_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_busy_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (busy_clr),
        .inc  (busy_inc),
        .last (busy_last)
    );

    hpe_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_done_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (done_clr),
        .inc  (done_inc),
        .last (done_last)
    );

    hpe_fsm #(.BUSY_BIT(BUSY_BIT), .DONE_BIT(DONE_BIT)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_code   (cmd_code),
        .map        (map),
        .cmd_ready  (cmd_ready),
        .acc_req    (acc_req),
        .acc_write  (acc_write),
        .acc_index  (acc_index),
        .acc_wdata  (acc_wdata),
        .acc_done   (acc_done),
        .acc_rdata  (acc_rdata),
        .busy_last  (busy_last),
        .done_last  (done_last),
        .busy_inc   (busy_inc),
        .busy_clr   (busy_clr),
        .done_inc   (done_inc),
        .done_clr   (done_clr),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_status (rsp_status),
        .rsp_ext    (rsp_ext),
        .rsp_ctlr   (rsp_ctlr)
    );

    assert_badcmd_noacc_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && cmd_valid && !map.ok) |=> (!acc_req && rsp_valid))
        else $error("unknown command started an access");

    assert_ready_idle_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!acc_req && !rsp_valid))
        else $error("ready while busy");

endmodule

// File: tb/hp_slot_cmd_engine_bench.sv
module hp_slot_cmd_engine_bench;

    localparam int MAXT = 60;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_code = '0, slot_idx = '0, bus_idx = '0;
    logic       cmd_ready, acc_req, acc_write;
    logic [7:0] acc_index, acc_wdata;
    logic       acc_done = 1'b0;
    logic [7:0] acc_rdata = '0;
    logic       rsp_valid;
    logic [1:0] rsp_err;
    logic [7:0] rsp_status, rsp_ext, rsp_ctlr;

    hp_slot_cmd_engine #(.MAX_TRIES(MAXT)) u_hp_slot_cmd_engine (
        .clk(clk), .rst(rst), .tick(tick),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_code(cmd_code), .slot_idx(slot_idx), .bus_idx(bus_idx),
        .acc_req(acc_req), .acc_write(acc_write), .acc_index(acc_index),
        .acc_wdata(acc_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_status(rsp_status),
        .rsp_ext(rsp_ext), .rsp_ctlr(rsp_ctlr)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [16:0] exp_acc[$];
    string       exp_acc_tag[$];
    logic [25:0] exp_rsp[$];
    string       exp_rsp_tag[$];
    logic [7:0]  ctlr_stat[$];
    bit          rsp_seen = 1'b0;
    int          lat = 0;
    int          tick_cnt = 0;

    function automatic logic [7:0] reg_value(input logic [7:0] idx);
        return idx ^ 8'hA5;
    endfunction

    task automatic push_acc(input bit w, input logic [7:0] idx, input logic [7:0] wd, input string tag);
        exp_acc.push_back({w, idx, wd});
        exp_acc_tag.push_back(tag);
    endtask

    task automatic push_poll(input string tag);
        push_acc(1'b0, 8'h0F, 8'h00, tag);
    endtask

    task automatic push_rsp(input logic [1:0] e, input logic [7:0] s, input logic [7:0] x,
                            input logic [7:0] c, input string tag);
        exp_rsp.push_back({e, s, x, c});
        exp_rsp_tag.push_back(tag);
    endtask

    // sequencer, controller model, tick and per-clock comparison
    always @(negedge clk) begin
        tick = 1'b0;
        if (!rst) begin
            tick_cnt++;
            if (tick_cnt % 5 == 0) tick = 1'b1;
        end
        if (rsp_valid) begin
            logic [25:0] got;
            got = {rsp_err, rsp_status, rsp_ext, rsp_ctlr};
            checks++;
            if (exp_rsp.size() == 0) begin
                fails++;
                $display("FAIL R11 unexpected response actual=%h expected=none", got);
            end else begin
                logic [25:0] want;
                string t;
                want = exp_rsp.pop_front();
                t = exp_rsp_tag.pop_front();
                if (got !== want) begin
                    fails++;
                    $display("FAIL %s response actual=%h expected=%h", t, got, want);
                end
            end
            rsp_seen = 1'b1;
        end
        if (acc_done) begin
            acc_done = 1'b0;
            lat = 0;
        end else if (acc_req) begin
            lat++;
            if (lat == 2) begin
                logic [16:0] got_a;
                got_a = {acc_write, acc_index, acc_wdata};
                checks++;
                if (exp_acc.size() == 0) begin
                    fails++;
                    $display("FAIL R4 unexpected access actual=%h expected=none", got_a);
                end else begin
                    logic [16:0] want_a;
                    string ta;
                    want_a = exp_acc.pop_front();
                    ta = exp_acc_tag.pop_front();
                    if (got_a !== want_a) begin
                        fails++;
                        $display("FAIL %s access actual=%h expected=%h", ta, got_a, want_a);
                    end
                end
                if (!acc_write) begin
                    if (acc_index == 8'h0F)
                        acc_rdata = (ctlr_stat.size() != 0) ? ctlr_stat.pop_front() : 8'h02;
                    else
                        acc_rdata = reg_value(acc_index);
                end
                acc_done = 1'b1;
            end
        end
    end

    task automatic issue(input bit w, input logic [7:0] code, input logic [7:0] slot,
                         input logic [7:0] bus);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        rsp_seen  = 1'b0;
        cmd_valid = 1'b1;
        cmd_write = w;
        cmd_code  = code;
        slot_idx  = slot;
        bus_idx   = bus;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_seen) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic leftovers(input string tag);
        checks++;
        if (exp_acc.size() != 0 || exp_rsp.size() != 0) begin
            fails++;
            $display("FAIL %s pending expectations actual=%0d/%0d expected=0/0",
                     tag, exp_acc.size(), exp_rsp.size());
            exp_acc.delete(); exp_acc_tag.delete();
            exp_rsp.delete(); exp_rsp_tag.delete();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R11)
        checks++;
        if (!(cmd_ready === 1'b1 && acc_req === 1'b0 && rsp_valid === 1'b0)) begin
            fails++;
            $display("FAIL R11 reset state actual=%b%b%b expected=100", cmd_ready, acc_req, rsp_valid);
        end

        // R1 controller-wide writes
        push_poll("R1"); push_acc(1, 8'h0F, 8'h00, "R1"); push_poll("R1");
        push_rsp(2'd0, 8'h00, 8'h00, 8'h02, "R1");
        issue(1, 8'h00, 8'h03, 8'h01); leftovers("R1");
        push_poll("R1"); push_acc(1, 8'h0F, 8'h07, "R1"); push_poll("R1");
        push_rsp(2'd0, 8'h00, 8'h00, 8'h02, "R1");
        issue(1, 8'h07, 8'h09, 8'h01); leftovers("R1");

        // R2 slot and bus writes
        push_poll("R2"); push_acc(1, 8'h09, 8'h04, "R2"); push_poll("R2");
        push_rsp(2'd0, 8'h00, 8'h00, 8'h02, "R2");
        issue(1, 8'h04, 8'h09, 8'h00); leftovers("R2");
        push_poll("R2"); push_acc(1, 8'h20, 8'h22, "R2"); push_poll("R2");
        push_rsp(2'd0, 8'h00, 8'h00, 8'h02, "R2");
        issue(1, 8'h22, 8'h00, 8'h02); leftovers("R2");

        // R8 checked write: busy, then idle-unfinished, then finished
        ctlr_stat.push_back(8'h00); ctlr_stat.push_back(8'h01);
        ctlr_stat.push_back(8'h00); ctlr_stat.push_back(8'h02);
        push_poll("R8"); push_acc(1, 8'h05, 8'h03, "R8");
        push_poll("R8"); push_poll("R8"); push_poll("R8");
        push_rsp(2'd0, 8'h00, 8'h00, 8'h02, "R8");
        issue(1, 8'h03, 8'h05, 8'h00); leftovers("R8");

        // R9 unchecked write finishes on first idle poll even if not finished
        ctlr_stat.push_back(8'h00); ctlr_stat.push_back(8'h00);
        push_poll("R9"); push_acc(1, 8'h02, 8'h13, "R9"); push_poll("R9");
        push_rsp(2'd0, 8'h00, 8'h00, 8'h00, "R9");
        issue(1, 8'h13, 8'h02, 8'h00); leftovers("R9");

        // R3 read map
        push_poll("R3"); push_acc(0, 8'h07, 8'h00, "R3");
        push_rsp(2'd0, reg_value(8'h07), 8'h00, 8'h02, "R3");
        issue(0, 8'h01, 8'h07, 8'h00); leftovers("R3");
        push_poll("R3"); push_acc(0, 8'h14, 8'h00, "R3");
        push_rsp(2'd0, reg_value(8'h14), 8'h00, 8'h02, "R3");
        issue(0, 8'h02, 8'h04, 8'h00); leftovers("R3");
        push_poll("R3"); push_acc(0, 8'h21, 8'h00, "R3");
        push_rsp(2'd0, reg_value(8'h21), 8'h00, 8'h02, "R3");
        issue(0, 8'h03, 8'h00, 8'h03); leftovers("R3");
        push_poll("R3"); push_acc(0, 8'h28, 8'h00, "R3");
        push_rsp(2'd0, reg_value(8'h28), 8'h00, 8'h02, "R3");
        issue(0, 8'h04, 8'h00, 8'h00); leftovers("R3");
        push_poll("R3"); push_acc(0, 8'h25, 8'h00, "R3");
        push_rsp(2'd0, reg_value(8'h25), 8'h00, 8'h02, "R3");
        issue(0, 8'h05, 8'h00, 8'h00); leftovers("R3");
        push_poll("R3"); push_acc(0, 8'h27, 8'h00, "R3");
        push_rsp(2'd0, reg_value(8'h27), 8'h00, 8'h02, "R3");
        issue(0, 8'h06, 8'h00, 8'h00); leftovers("R3");

        // R10 controller status read: single poll only
        ctlr_stat.push_back(8'h80);
        push_poll("R10");
        push_rsp(2'd0, 8'h80, 8'h00, 8'h80, "R10");
        issue(0, 8'h00, 8'h01, 8'h00); leftovers("R10");

        // R7 combined read
        push_poll("R7"); push_acc(0, 8'h06, 8'h00, "R7");
        push_poll("R7"); push_acc(0, 8'h16, 8'h00, "R7");
        push_rsp(2'd0, reg_value(8'h06), reg_value(8'h16), 8'h02, "R7");
        issue(0, 8'h07, 8'h06, 8'h00); leftovers("R7");

        // R7 combined read with the middle wait timing out
        ctlr_stat.push_back(8'h00);
        for (int i = 0; i < MAXT; i++) ctlr_stat.push_back(8'h01);
        push_poll("R7"); push_acc(0, 8'h06, 8'h00, "R7");
        for (int i = 0; i < MAXT; i++) push_poll("R7");
        push_rsp(2'd2, reg_value(8'h06), 8'h00, 8'h01, "R7");
        issue(0, 8'h07, 8'h06, 8'h00); leftovers("R7");

        // R6 busy timeout before a write
        for (int i = 0; i < MAXT; i++) ctlr_stat.push_back(8'h01);
        for (int i = 0; i < MAXT; i++) push_poll("R6");
        push_rsp(2'd2, 8'h00, 8'h00, 8'h01, "R6");
        issue(1, 8'h03, 8'h02, 8'h00); leftovers("R6");

        // R6 boundary: one fewer busy reading still proceeds
        for (int i = 0; i < MAXT - 1; i++) ctlr_stat.push_back(8'h01);
        ctlr_stat.push_back(8'h00);
        for (int i = 0; i < MAXT; i++) push_poll("R6");
        push_acc(0, 8'h27, 8'h00, "R6");
        push_rsp(2'd0, reg_value(8'h27), 8'h00, 8'h00, "R6");
        issue(0, 8'h06, 8'h00, 8'h00); leftovers("R6");

        // R8 completion timeout
        ctlr_stat.push_back(8'h00);
        for (int i = 0; i < MAXT; i++) ctlr_stat.push_back(8'h00);
        push_poll("R8"); push_acc(1, 8'h01, 8'h02, "R8");
        for (int i = 0; i < MAXT; i++) push_poll("R8");
        push_rsp(2'd3, 8'h00, 8'h00, 8'h00, "R8");
        issue(1, 8'h02, 8'h01, 8'h00); leftovers("R8");

        // R4 unknown commands
        push_rsp(2'd1, 8'h00, 8'h00, 8'h00, "R4");
        issue(1, 8'h30, 8'h01, 8'h00); leftovers("R4");
        push_rsp(2'd1, 8'h00, 8'h00, 8'h00, "R4");
        issue(0, 8'h09, 8'h01, 8'h00); leftovers("R4");
        push_rsp(2'd1, 8'h00, 8'h00, 8'h00, "R4");
        issue(1, 8'h09, 8'h01, 8'h00); leftovers("R4");

        // R5 busy twice then idle, before a revision read
        ctlr_stat.push_back(8'h01); ctlr_stat.push_back(8'h01); ctlr_stat.push_back(8'h00);
        push_poll("R5"); push_poll("R5"); push_poll("R5");
        push_acc(0, 8'h25, 8'h00, "R5");
        push_rsp(2'd0, reg_value(8'h25), 8'h00, 8'h00, "R5");
        issue(0, 8'h05, 8'h00, 8'h00); leftovers("R5");

        // R11 ready again after all traffic
        @(negedge clk);
        checks++;
        if (cmd_ready !== 1'b1) begin
            fails++;
            $display("FAIL R11 ready after traffic actual=%b expected=1", cmd_ready);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule